// File: doc/BRIEF.md
# Serial Bit Link with Strobed Decoder Receiver

This block moves an eight-bit word of switch levels across a single serial data line, accompanied by a three-bit address bus. A free-running binary counter divides the system clock, and a group of its upper bits forms the address. On the sending side, a multiplexer puts the addressed input bit onto the data line. On the receiving side, a decoder uses that same data line as its enable input, so it raises the output strobe for the addressed position only when the bit being carried is 1.

The receiver does not rebuild a parallel word. Over one full sweep of all eight addresses, each output is pulsed in its own slot exactly when its input bit is set. When the outputs drive LEDs, the eye averages the pulses into a steady pattern. The data line is also brought out on a monitor pin.

The counter width and the tap position are parameters. On silicon, the defaults give slots that are visible to the eye. In simulation, a short divider lets all eight addresses be swept in a few dozen cycles.

Top module: `tdm_bit_link`

## Requirements
- R1: While the synchronous active-high reset `rst` is high at a rising clock edge, the divider counter clears to zero, so `slot_addr` reads 0 after that edge.
- R2: With `rst` low, the divider counter increases by exactly one on every rising clock edge. `slot_addr` is the counter's bits `TAP_LSB+2` down to `TAP_LSB`, so it advances by one every `2**TAP_LSB` clocks.
- R3: `line_mon` always equals `sw_in[slot_addr]`, where bit 0 of `sw_in` is address 0.
- R4: `led_out[k]` is 1 only when `slot_addr == k` and `sw_in[k]` is 1; every other bit of `led_out` is 0, so at most one strobe is high.
- R5: The send and receive paths are combinational: a change on `sw_in` reaches `line_mon` and `led_out` within the current address slot, with no clock edge in between.
- R6: The counter wraps modulo `2**CNT_W` without reset, so `slot_addr` goes from 7 back to 0 and then repeats the same order.
- R7: Over one full sweep of the eight addresses with `sw_in` held steady, the set of outputs that were strobed equals `sw_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the counter advances on the rising edge |
| rst | input | 1 | Synchronous active-high clear of the divider counter |
| sw_in | input | 8 | Parallel input levels, bit k carried in address slot k |
| slot_addr | output | 3 | Address bus taken from the divider tap |
| line_mon | output | 1 | Serial data line, brought out for monitoring |
| led_out | output | 8 | Decoder strobes, at most one high at a time |

## Verification
The in-module assertions check four things on every cycle: the single-step counting and the clear on reset, the wrap from all-ones to zero, and the relationship between the strobes, the address and the data line (at most one strobe high, any strobe at the current address, and the strobe OR equal to the line). Some behaviours can only be shown by the bench's scenarios. These are the mapping of the line onto the correct input bit, the completeness of the strobes over a sweep for many different words, and the same-slot response to a switch change without any clock edge.

// File: rtl/tdm_bit_link.sv
module tdm_bit_link #(
  parameter int CNT_W   = 28,
  parameter int TAP_LSB = 25
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sw_in,
  output logic [2:0] slot_addr,
  output logic       line_mon,
  output logic [7:0] led_out
);
  localparam int ADDR_W = 3;
  localparam int LANES  = 1 << ADDR_W;

  logic [CNT_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst) div_cnt <= '0;
    else     div_cnt <= div_cnt + 1'b1;
  end

  assign slot_addr = div_cnt[TAP_LSB +: ADDR_W];
  assign line_mon  = sw_in[slot_addr];

  for (genvar k = 0; k < LANES; k++) begin : g_strobe
    assign led_out[k] = line_mon && (slot_addr == ADDR_W'(k));
  end

  a_r1_clear: assert property (@(posedge clk) rst |=> (slot_addr == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(div_cnt) != '1)) |-> (div_cnt == $past(div_cnt) + 1'b1));

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(div_cnt) == '1)) |-> (div_cnt == '0));

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(led_out));

  a_r4_slot: assert property (@(posedge clk) disable iff (rst)
    (led_out != '0) |-> led_out[slot_addr]);

  a_r3_line: assert property (@(posedge clk) disable iff (rst)
    ((|led_out) == line_mon));
endmodule

// File: tb/tb_tdm_bit_link.sv
module tb_tdm_bit_link;
  localparam int CW  = 6;
  localparam int TAP = 3;
  localparam int SWEEP = 1 << CW;

  localparam logic [7:0] VEC [8] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'h96};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sw_in = 8'h00;
  logic [2:0] slot_addr;
  logic line_mon;
  logic [7:0] led_out;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tdm_bit_link #(.CNT_W(CW), .TAP_LSB(TAP)) dut (
    .clk(clk), .rst(rst), .sw_in(sw_in),
    .slot_addr(slot_addr), .line_mon(line_mon), .led_out(led_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) n = 0; else n = (n + 1) % SWEEP;
    @(negedge clk);
  endtask

  function automatic logic [2:0] exp_addr();
    return 3'((n >> TAP) & 7);
  endfunction

  function automatic logic [7:0] exp_led(input logic [7:0] w, input logic [2:0] a);
    return w[a] ? (8'h01 << a) : 8'h00;
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step();
    step();
    chk("R1 reset address", 8'(slot_addr), 8'h00);
    rst = 1'b0;
    for (int v = 0; v < 8; v++) begin
      logic [7:0] seen;
      seen = 8'h00;
      sw_in = VEC[v];
      for (int c = 0; c < SWEEP; c++) begin
        step();
        seen |= led_out;
        chk("R2 address", 8'(slot_addr), 8'(exp_addr()));
        chk("R3 line", 8'(line_mon), 8'(VEC[v][exp_addr()]));
        chk("R4 strobe", led_out, exp_led(VEC[v], exp_addr()));
      end
      chk("R7 sweep", seen, VEC[v]);
    end

    while (exp_addr() != 3'd7 || ((n + 1) % (1 << TAP)) != 0) step();
    chk("R6 before wrap", 8'(slot_addr), 8'h07);
    step();
    chk("R6 after wrap", 8'(slot_addr), 8'h00);

    sw_in = 8'h00;
    step();
    step();
    chk("R5 baseline", led_out, 8'h00);
    sw_in = 8'h01;
    #1;
    chk("R5 same slot led", led_out, 8'h01);
    chk("R5 same slot line", 8'(line_mon), 8'h01);
    sw_in = 8'hFE;
    #1;
    chk("R5 drop", led_out, 8'h00);

    sw_in = 8'hFF;
    for (int c = 0; c < 20; c++) step();
    rst = 1'b1;
    step();
    chk("R1 mid-run reset", 8'(slot_addr), 8'h00);
    chk("R1 strobe at 0", led_out, 8'h01);
    rst = 1'b0;
    for (int c = 0; c < (1 << TAP); c++) step();
    chk("R2 first advance", 8'(slot_addr), 8'h01);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule